// File: doc/BRIEF.md
# Scanline Cycle Scheduler with Countdown Interrupt Timers

This block keeps the time base for a processor that shares its memory with a video refresh engine. A free-running cycle counter advances on every clock. A position counter splits time into lines of 114 cycles. The first 9 cycles of each line are taken by memory refresh, and during them the block raises a stall output that holds the processor. A line index counts lines through a frame of 312 lines and then starts again at zero.

Three timers sit beside the time base. Each can be armed with a target value on the free-running counter, or disarmed. When the counter equals an armed target, the timer's bit in an 8-bit active-low status register drops to 0 and the timer disarms itself. A bit stays low until an acknowledge write sets it back to 1.

The block asks the processor to take an interrupt whenever its interrupt-disable flag is clear and any status bit is low. For that entry it also supplies the flag byte the processor pushes and the address of the vector it reads. The control and status pins are plain level signals. No pin carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `scanline_sched`

## Requirements
- R1: `line_cyc` counts 0,1,...,113 and then returns to 0. `stall` is 1 exactly when `line_cyc` is 0 to 8, which gives 9 stalled cycles per line, all at the start of the line.
- R2: `line_idx` increments in the cycle after `line_cyc` was 113. It goes from 311 back to 0.
- R3: `cyc_cnt` is 0 in the first cycle after reset and increases by one on every clock.
- R4: A write with `tmr_wr`=1 selects timer `tmr_sel` (0, 1 or 2). With `tmr_en`=1 it arms that timer with `tmr_target`; with `tmr_en`=0 it disarms it. A new write replaces any earlier target. Timer k owns status bit k (mask values 1, 2 and 4). The target must lie after the cycle of the write.
- R5: An armed timer whose target equals `cyc_cnt` in a cycle clears its status bit to 0 from the next cycle on and disarms itself. It does so even when that cycle falls inside the refresh stall. Two timers with the same target clear both bits together.
- R6: `ack_wr`=1 sets to 1 every status bit that is 1 in `ack_mask`, from the next cycle. When a timer expires in the same cycle on the same bit, the expiry wins and the bit stays 0.
- R7: After reset, `irq_status` is 8'hFF, all timers are disarmed, and `cyc_cnt`, `line_cyc` and `line_idx` are 0.
- R8: `irq_take` is 1 exactly when `cpu_flags` bit 2 (interrupt disable) is 0 and `irq_status` is not 8'hFF.
- R9: `push_flags` equals `cpu_flags` with bit 5 forced to 1 and bit 4 (break) forced to 0. `irq_vector` is 16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_sel | input | 2 | Timer index for the write |
| tmr_en | input | 1 | 1 arms the timer with the target, 0 disarms it |
| tmr_target | input | 24 | Target value of the cycle counter |
| ack_wr | input | 1 | Acknowledge strobe |
| ack_mask | input | 8 | Status bits to set back to 1 |
| cpu_flags | input | 8 | Current processor flag byte; bit 2 is interrupt disable |
| cyc_cnt | output | 24 | Free-running cycle counter |
| line_cyc | output | 7 | Cycle position within the line |
| line_idx | output | 9 | Line index within the frame |
| stall | output | 1 | Refresh stall for the processor |
| irq_status | output | 8 | Active-low timer status |
| irq_take | output | 1 | Interrupt request to the processor |
| push_flags | output | 8 | Flag byte to push on interrupt entry |
| irq_vector | output | 16 | Address of the interrupt vector |

## Verification
Two kinds of same-cycle collision are covered.

The first is a timer expiring inside the refresh window. The bench places a target at position 3 of a future line and first confirms that `stall` is high in that cycle. It then expects the status bit to be low in the very next cycle, just as for an expiry outside the window.

The second is an expiry meeting an acknowledge for the same bit. The acknowledge is driven in exactly the target cycle, and the bit must still read 0 afterwards. A later acknowledge must then restore 8'hFF.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int CNT_W      = 24;
  localparam int NUM_TMR    = 3;
  localparam int STAT_W     = 8;
  localparam int LINE_CYC   = 114;
  localparam int REFRESH    = 9;
  localparam int LINES      = 312;
  localparam logic [15:0] IRQ_VEC = 16'hFFFE;
  localparam int FLAG_IDIS  = 2;
  localparam int FLAG_BRK   = 4;
  localparam int FLAG_ONE   = 5;
endpackage

// File: rtl/sched_line_timer.sv
module sched_line_timer #(
  parameter int LINE_CYC = 114,
  parameter int REFRESH  = 9,
  parameter int LINES    = 312,
  parameter int PW       = $clog2(LINE_CYC),
  parameter int LW       = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] pos,
  output logic [LW-1:0] line,
  output logic          stall
);
  localparam logic [PW-1:0] LAST_POS  = PW'(LINE_CYC - 1);
  localparam logic [PW-1:0] REF_END   = PW'(REFRESH);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      line <= '0;
    end else if (pos == LAST_POS) begin
      pos  <= '0;
      line <= (line == LAST_LINE) ? '0 : line + 1'b1;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  assign stall = (pos < REF_END);

  // R1: position wraps after the last cycle of a line
  a_r1_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST_POS) |=> (pos == '0));
  // R1: the stall window ends exactly at the refresh length
  a_r1_stall_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (pos == REF_END));
  // R2: frame wrap
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST_POS && line == LAST_LINE) |=> (line == '0));
  // R2: line index holds inside a line
  a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != LAST_POS) |=> $stable(line));
endmodule

// File: rtl/sched_cd_timer.sv
module sched_cd_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr,
  input  logic             en,
  input  logic [CNT_W-1:0] target,
  output logic             fire
);
  logic             armed;
  logic [CNT_W-1:0] tgt;

  assign fire = armed && (cnt == tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      tgt   <= '0;
    end else if (wr) begin
      armed <= en;
      tgt   <= target;
    end else if (fire) begin
      armed <= 1'b0;
    end
  end

  // R5: an expiry disarms the timer unless a write re-arms it
  a_r5_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr) |=> !armed);
  // R4: a disarming write leaves the timer silent next cycle
  a_r4_disarm_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !en) |=> !fire);
endmodule

// File: rtl/sched_irq_status.sv
module sched_irq_status #(
  parameter int STAT_W  = 8,
  parameter int NUM_TMR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TMR-1:0] fire,
  input  logic               ack_wr,
  input  logic [STAT_W-1:0]  ack_mask,
  output logic [STAT_W-1:0]  status
);
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] set_vec;

  assign clr_vec = STAT_W'(fire);
  assign set_vec = ack_wr ? ack_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '1;
    else        status <= (status | set_vec) & ~clr_vec;
  end

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_chk
    // R5: expiry clears the bit, also against a same-cycle acknowledge (R6)
    a_r5_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fire[k] |=> !status[k]);
    // R5: a bit only falls after its own timer expired
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[k]) |-> $past(fire[k]));
    // R6: acknowledge without expiry restores the bit
    a_r6_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && ack_mask[k] && !fire[k]) |=> status[k]);
  end
endmodule

// File: rtl/scanline_sched.sv
module scanline_sched
  import sched_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int NT  = NUM_TMR,
  parameter int SW  = STAT_W,
  parameter int LC  = LINE_CYC,
  parameter int RC  = REFRESH,
  parameter int NL  = LINES,
  parameter int PW  = $clog2(LC),
  parameter int LW  = $clog2(NL),
  parameter int TSW = $clog2(NT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tmr_wr,
  input  logic [TSW-1:0] tmr_sel,
  input  logic           tmr_en,
  input  logic [CW-1:0]  tmr_target,
  input  logic           ack_wr,
  input  logic [SW-1:0]  ack_mask,
  input  logic [7:0]     cpu_flags,
  output logic [CW-1:0]  cyc_cnt,
  output logic [PW-1:0]  line_cyc,
  output logic [LW-1:0]  line_idx,
  output logic           stall,
  output logic [SW-1:0]  irq_status,
  output logic           irq_take,
  output logic [7:0]     push_flags,
  output logic [15:0]    irq_vector
);
  logic [NT-1:0] fire;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_cnt <= '0;
    else        cyc_cnt <= cyc_cnt + 1'b1;
  end

  sched_line_timer #(.LINE_CYC(LC), .REFRESH(RC), .LINES(NL), .PW(PW), .LW(LW)) u_line (
    .clk(clk), .rst_n(rst_n), .pos(line_cyc), .line(line_idx), .stall(stall)
  );

  for (genvar k = 0; k < NT; k++) begin : g_tmr
    logic sel_k;
    assign sel_k = tmr_wr && (tmr_sel == TSW'(k));
    sched_cd_timer #(.CNT_W(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .cnt(cyc_cnt), .wr(sel_k), .en(tmr_en),
      .target(tmr_target), .fire(fire[k])
    );
  end

  sched_irq_status #(.STAT_W(SW), .NUM_TMR(NT)) u_stat (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ack_wr(ack_wr), .ack_mask(ack_mask),
    .status(irq_status)
  );

  assign irq_take = !cpu_flags[FLAG_IDIS] && (irq_status != '1);

  always_comb begin
    push_flags           = cpu_flags;
    push_flags[FLAG_ONE] = 1'b1;
    push_flags[FLAG_BRK] = 1'b0;
  end

  assign irq_vector = IRQ_VEC;

  // R3: free-running counter advances by one each clock
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));
  // R8: no request while interrupts are masked
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_flags[FLAG_IDIS] |-> !irq_take);
endmodule

// File: tb/test_scanline_sched.sv
module test_scanline_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_wr = 1'b0;
  logic [1:0]  tmr_sel = '0;
  logic        tmr_en = 1'b0;
  logic [23:0] tmr_target = '0;
  logic        ack_wr = 1'b0;
  logic [7:0]  ack_mask = '0;
  logic [7:0]  cpu_flags = 8'h04;
  logic [23:0] cyc_cnt;
  logic [6:0]  line_cyc;
  logic [8:0]  line_idx;
  logic        stall;
  logic [7:0]  irq_status;
  logic        irq_take;
  logic [7:0]  push_flags;
  logic [15:0] irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mc = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) mc <= 0;
    else        mc <= mc + 1;
  end

  scanline_sched i_scanline_sched (
    .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .tmr_sel(tmr_sel), .tmr_en(tmr_en),
    .tmr_target(tmr_target), .ack_wr(ack_wr), .ack_mask(ack_mask), .cpu_flags(cpu_flags),
    .cyc_cnt(cyc_cnt), .line_cyc(line_cyc), .line_idx(line_idx), .stall(stall),
    .irq_status(irq_status), .irq_take(irq_take), .push_flags(push_flags),
    .irq_vector(irq_vector)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, mc);
    end
  endtask

  task automatic wait_mc(input int target);
    while (mc < target) @(negedge clk);
  endtask

  task automatic tmr_write(input int sel, input bit en, input int tgt);
    tmr_wr = 1'b1; tmr_sel = 2'(sel); tmr_en = en; tmr_target = 24'(tgt);
    @(negedge clk);
    tmr_wr = 1'b0; tmr_en = 1'b0;
  endtask

  task automatic ack(input logic [7:0] m);
    ack_wr = 1'b1; ack_mask = m;
    @(negedge clk);
    ack_wr = 1'b0; ack_mask = '0;
  endtask

  task automatic t_reset_state;
    chk(irq_status == 8'hFF, "R7 status", int'(irq_status), 'hFF);
    chk(cyc_cnt == 0, "R7 cyc_cnt", int'(cyc_cnt), 0);
    chk(line_cyc == 0 && line_idx == 0, "R7 line", int'(line_idx), 0);
    chk(irq_take == 0, "R8 take at reset", int'(irq_take), 0);
  endtask

  task automatic t_frame;
    for (int n = 0; n < 312 * 114 + 300; n++) begin
      int p = mc % 114;
      int l = (mc / 114) % 312;
      chk(cyc_cnt == 24'(mc), "R3 cyc_cnt", int'(cyc_cnt), mc);
      chk(int'(line_cyc) == p, "R1 line_cyc", int'(line_cyc), p);
      chk(stall == (p < 9), "R1 stall", int'(stall), int'(p < 9));
      chk(int'(line_idx) == l, "R2 line_idx", int'(line_idx), l);
      @(negedge clk);
    end
    chk(irq_status == 8'hFF, "R7 disarmed timers silent", int'(irq_status), 'hFF);
  endtask

  task automatic t_basic_fire;
    int t = mc + 40;
    tmr_write(0, 1'b1, t);
    wait_mc(t);
    chk(irq_status == 8'hFF, "R5 before target", int'(irq_status), 'hFF);
    @(negedge clk);
    chk(irq_status == 8'hFE, "R5 timer0 bit0", int'(irq_status), 'hFE);
    cpu_flags = 8'h00;
    #0 chk(irq_take == 1, "R8 take unmasked", int'(irq_take), 1);
    cpu_flags = 8'h04;
    #1 chk(irq_take == 0, "R8 masked", int'(irq_take), 0);
    ack(8'h01);
    chk(irq_status == 8'hFF, "R6 ack restores", int'(irq_status), 'hFF);
    cpu_flags = 8'h00;
    #1 chk(irq_take == 0, "R8 idle status", int'(irq_take), 0);
    cpu_flags = 8'h04;
  endtask

  task automatic t_stall_fire;
    int t = ((mc / 114) + 2) * 114 + 3;
    tmr_write(1, 1'b1, t);
    wait_mc(t);
    chk(stall == 1'b1, "R1 stall at target", int'(stall), 1);
    @(negedge clk);
    chk(irq_status == 8'hFD, "R5 fire in stall", int'(irq_status), 'hFD);
    ack(8'h02);
    chk(irq_status == 8'hFF, "R6 ack bit1", int'(irq_status), 'hFF);
  endtask

  task automatic t_ack_race;
    int t = mc + 30;
    tmr_write(0, 1'b1, t);
    wait_mc(t);
    ack_wr = 1'b1; ack_mask = 8'h01;
    @(negedge clk);
    ack_wr = 1'b0; ack_mask = '0;
    chk(irq_status == 8'hFE, "R6 expiry beats ack", int'(irq_status), 'hFE);
    @(negedge clk);
    ack(8'hFF);
    chk(irq_status == 8'hFF, "R6 later ack", int'(irq_status), 'hFF);
  endtask

  task automatic t_retarget_disarm;
    int t1 = mc + 20;
    int t2 = mc + 50;
    tmr_write(2, 1'b1, t1);
    tmr_write(2, 1'b1, t2);
    wait_mc(t1 + 2);
    chk(irq_status == 8'hFF, "R4 old target replaced", int'(irq_status), 'hFF);
    wait_mc(t2 + 1);
    chk(irq_status == 8'hFB, "R4 new target timer2 bit2", int'(irq_status), 'hFB);
    ack(8'h04);
    t1 = mc + 20;
    tmr_write(0, 1'b1, t1);
    tmr_write(0, 1'b0, t1);
    wait_mc(t1 + 3);
    chk(irq_status == 8'hFF, "R4 disarm", int'(irq_status), 'hFF);
  endtask

  task automatic t_two_timers;
    int t = mc + 25;
    tmr_write(0, 1'b1, t);
    tmr_write(2, 1'b1, t);
    wait_mc(t + 1);
    chk(irq_status == 8'hFA, "R5 two timers same cycle", int'(irq_status), 'hFA);
    ack(8'h01);
    chk(irq_status == 8'hFB, "R6 partial ack", int'(irq_status), 'hFB);
    ack(8'h04);
    chk(irq_status == 8'hFF, "R6 final ack", int'(irq_status), 'hFF);
  endtask

  task automatic t_push;
    cpu_flags = 8'hFF;
    #1 chk(push_flags == 8'hEF, "R9 push all ones", int'(push_flags), 'hEF);
    cpu_flags = 8'h00;
    #1 chk(push_flags == 8'h20, "R9 push zeros", int'(push_flags), 'h20);
    chk(irq_vector == 16'hFFFE, "R9 vector", int'(irq_vector), 'hFFFE);
    cpu_flags = 8'h04;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_frame();
    t_basic_fire();
    t_stall_fire();
    t_ack_race();
    t_retarget_disarm();
    t_two_timers();
    t_push();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", mc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule